// File: doc/BRIEF.md
# Closed Caption Line Encoder

This block generates the digital level sequence for one caption or extended-data line of a video field. Each field has its own two-byte message, supplied through per-field data inputs and a write strobe. On the selected line the block emits a clock run-in burst, a start code and the two bytes, each followed by a generated parity bit. Everywhere else it holds the blanking level. A downstream filter and DAC turn the level code into the analog waveform.

The bit rate is tied to the line rate: 32 bit periods fill exactly one line. A phase accumulator on the pixel clock makes this hold for both the 60 Hz line length (858 pixel clocks) and the 50 Hz line length (864 pixel clocks). A new line is recognised when the line-number input changes. The first pixel clock that carries the new number is pixel 0 of that line.

Top module: `cc_line_enc`

## Requirements
- R1: Encoding takes place only on the line whose number equals 21 plus the 3-bit `line_ofs` input (lines 21 to 28). On every other line `cc_level` stays at the blanking code and `data_act` stays low.
- R2: The line holds 64 half-bit slots numbered k = 0..63, with bit period b = (k-8)/2. Periods 0 to 6 are seven run-in cycles: the even half-slot is high and the odd half-slot is low. Periods 7, 8 and 9 carry the start code low, low, high.
- R3: Periods 10 to 16 carry data bits 0..6 of the first byte (`fX_data[6:0]`), least significant bit first. Period 17 carries that byte's odd parity. Periods 18 to 25 do the same for the second byte (`fX_data[14:8]`). Input bits 7 and 15 have no effect.
- R4: Half-slot k starts within two pixel clocks of k·L/64 after pixel 0, where L is 858 when `mode_50hz`=0 and 864 when `mode_50hz`=1.
- R5: `data_act` is high exactly for half-slots 8 to 59 of an encoded line. The level code is `LVL_HIGH` (200) for a one and `LVL_BLANK` (0) for a zero or for blanking.
- R6: If a field's data has not been written since that field's last encoded line, the line carries null bytes: data 0x00 with parity 1, that is 0x80, in both positions.
- R7: When the enable for the current field is low, the target line stays at blanking and `data_act` stays low. Pending written data is kept for the next enabled line.
- R8: After reset `cc_level` is the blanking code, `data_act` is low, and both fields count as not written.
- R9: Field 0 lines use `f0_data` and field 1 lines use `f1_data`. Each field keeps its own written/not-written state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_num | input | 10 | Current line number; a change marks pixel 0 of a new line |
| field_id | input | 1 | Current field, 0 or 1 |
| line_ofs | input | 3 | Line offset added to 21 |
| mode_50hz | input | 1 | 1 selects 864-pixel lines, 0 selects 858 |
| en_f0 | input | 1 | Encoding enable for field 0 |
| en_f1 | input | 1 | Encoding enable for field 1 |
| f0_data | input | 16 | Byte pair for field 0 |
| f0_wr | input | 1 | One-cycle strobe: f0_data is new |
| f1_data | input | 16 | Byte pair for field 1 |
| f1_wr | input | 1 | One-cycle strobe: f1_data is new |
| cc_level | output | 10 | Level code, blanking or data-high |
| data_act | output | 1 | High inside the data region of an encoded line |

## Verification
The assertions watch the timing skeleton on every cycle. The half-slot counter restarts at each new line and never advances by more than one. Ticks never fall on adjacent cycles. A level other than blanking appears only while `data_act` is high. Every encoded region opens on a high run-in half. A consumed write flag clears. The bench scenarios cover the rest: run-in and start code shape, bit order and parity, null substitution after a repeated line, the per-field data split, disabled fields that keep their pending data, offset line selection, and both line lengths. They do this by comparing the centre of every half-slot with an independently built expected line.

// File: rtl/cc_enc_pkg.sv
package cc_enc_pkg;
  localparam int HALF_SLOTS = 64;
  localparam int LEAD_BITS  = 4;
  localparam int RUNIN_BITS = 7;
  localparam int CODE_BITS  = 3;
  localparam int FRAME_BITS = RUNIN_BITS + CODE_BITS + 16;
  localparam int REGION_LO  = 2 * LEAD_BITS;
  localparam int REGION_HI  = 2 * (LEAD_BITS + FRAME_BITS);

  function automatic logic odd_par(input logic [6:0] d);
    return ~(^d);
  endfunction

  // byte pair with parity placed in bit 7 of each byte
  function automatic logic [15:0] build_payload(input logic [15:0] raw);
    return {odd_par(raw[14:8]), raw[14:8], odd_par(raw[6:0]), raw[6:0]};
  endfunction

  function automatic logic in_region(input logic [6:0] h);
    return (int'(h) >= REGION_LO) && (int'(h) < REGION_HI);
  endfunction

  // waveform value for half slot h of a frame carrying pay
  function automatic logic wave_hi(input logic [6:0] h, input logic [15:0] pay);
    int b;
    b = (int'(h) - REGION_LO) / 2;
    if (b < RUNIN_BITS) return ~h[0];
    if (b < RUNIN_BITS + CODE_BITS - 1) return 1'b0;
    if (b == RUNIN_BITS + CODE_BITS - 1) return 1'b1;
    return pay[b - RUNIN_BITS - CODE_BITS];
  endfunction
endpackage

// File: rtl/cc_bit_timer.sv
module cc_bit_timer #(
  parameter int LINE_60 = 858,
  parameter int LINE_50 = 864
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sol,
  input  logic       mode_50hz,
  output logic       tick,
  output logic [6:0] hcnt
);
  localparam int LMAX  = (LINE_60 > LINE_50) ? LINE_60 : LINE_50;
  localparam int ACC_W = $clog2(LMAX) + 2;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(cc_enc_pkg::HALF_SLOTS);
  localparam logic [6:0] SAT = 7'(cc_enc_pkg::HALF_SLOTS);

  logic [ACC_W-1:0] acc, acc_sum, period;
  logic wrap;

  always_comb begin
    period  = mode_50hz ? ACC_W'(LINE_50) : ACC_W'(LINE_60);
    acc_sum = acc + STEP;
    wrap    = acc_sum >= period;
    tick    = wrap && (hcnt != SAT) && !sol;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      hcnt <= SAT;
    end else if (sol) begin
      acc  <= '0;
      hcnt <= '0;
    end else begin
      acc <= wrap ? acc_sum - period : acc_sum;
      if (tick) hcnt <= hcnt + 7'd1;
    end
  end
endmodule

// File: rtl/cc_payload.sv
module cc_payload (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        field_id,
  input  logic [1:0]  wr_f,
  input  logic [15:0] f0_data,
  input  logic [15:0] f1_data,
  output logic [1:0]  take_f,
  output logic [1:0]  fresh,
  output logic [15:0] payload
);
  logic [15:0] raw [2];
  assign raw[0] = f0_data;
  assign raw[1] = f1_data;

  for (genvar i = 0; i < 2; i++) begin : g_field
    assign take_f[i] = take && (field_id == 1'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) fresh[i] <= 1'b0;
      else        fresh[i] <= wr_f[i] | (fresh[i] & ~take_f[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) payload <= '0;
    else if (take)
      payload <= fresh[field_id] ? cc_enc_pkg::build_payload(raw[field_id])
                                 : cc_enc_pkg::build_payload(16'h0000);
  end
endmodule

// File: rtl/cc_wave.sv
module cc_wave #(
  parameter int LVL_W = 10,
  parameter logic [LVL_W-1:0] LVL_BLANK = '0,
  parameter logic [LVL_W-1:0] LVL_HIGH = 200
) (
  input  logic [6:0]       hcnt,
  input  logic             active,
  input  logic [15:0]      payload,
  output logic [LVL_W-1:0] level,
  output logic             act
);
  always_comb begin
    act   = active && cc_enc_pkg::in_region(hcnt);
    level = (act && cc_enc_pkg::wave_hi(hcnt, payload)) ? LVL_HIGH : LVL_BLANK;
  end
endmodule

// File: rtl/cc_line_enc.sv
module cc_line_enc #(
  parameter int LINE_W = 10,
  parameter int OFS_W  = 3,
  parameter int BASE_LINE = 21,
  parameter int LINE_60 = 858,
  parameter int LINE_50 = 864,
  parameter int LVL_W = 10,
  parameter logic [LVL_W-1:0] LVL_BLANK = '0,
  parameter logic [LVL_W-1:0] LVL_HIGH = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_id,
  input  logic [OFS_W-1:0]  line_ofs,
  input  logic              mode_50hz,
  input  logic              en_f0,
  input  logic              en_f1,
  input  logic [15:0]       f0_data,
  input  logic              f0_wr,
  input  logic [15:0]       f1_data,
  input  logic              f1_wr,
  output logic [LVL_W-1:0]  cc_level,
  output logic              data_act
);
  logic [LINE_W-1:0] line_q, tgt_line;
  logic sol, line_hit, en_sel, take, active, tick;
  logic [6:0] hcnt;
  logic [1:0] wr_f, take_f, fresh;
  logic [15:0] payload;

  assign wr_f     = {f1_wr, f0_wr};
  assign sol      = line_num != line_q;
  assign tgt_line = LINE_W'(BASE_LINE) + LINE_W'(line_ofs);
  assign line_hit = line_num == tgt_line;
  assign en_sel   = field_id ? en_f1 : en_f0;
  assign take     = sol && line_hit && en_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      active <= 1'b0;
    end else begin
      line_q <= line_num;
      if (sol) active <= take;
    end
  end

  cc_bit_timer #(.LINE_60(LINE_60), .LINE_50(LINE_50)) u_timer (
    .clk(clk), .rst_n(rst_n), .sol(sol), .mode_50hz(mode_50hz),
    .tick(tick), .hcnt(hcnt)
  );

  cc_payload u_payload (
    .clk(clk), .rst_n(rst_n), .take(take), .field_id(field_id),
    .wr_f(wr_f), .f0_data(f0_data), .f1_data(f1_data),
    .take_f(take_f), .fresh(fresh), .payload(payload)
  );

  cc_wave #(.LVL_W(LVL_W), .LVL_BLANK(LVL_BLANK), .LVL_HIGH(LVL_HIGH)) u_wave (
    .hcnt(hcnt), .active(active), .payload(payload),
    .level(cc_level), .act(data_act)
  );
endmodule

// File: rtl/cc_line_enc_chk.sv
module cc_line_enc_chk #(
  parameter int LVL_W = 10,
  parameter logic [LVL_W-1:0] LVL_BLANK = '0,
  parameter logic [LVL_W-1:0] LVL_HIGH = 200
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sol,
  input logic             tick,
  input logic [6:0]       hcnt,
  input logic             data_act,
  input logic [LVL_W-1:0] level,
  input logic [1:0]       take_f,
  input logic [1:0]       wr_f,
  input logic [1:0]       fresh
);
  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sol |=> hcnt == 7'd0);
  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sol |=> (hcnt == $past(hcnt) || hcnt == $past(hcnt) + 7'd1));
  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R5
  blank_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_act |-> level == LVL_BLANK);
  // R2
  runin_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_act) |-> level == LVL_HIGH);
  // R6
  f0_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_f[0] && !wr_f[0]) |=> !fresh[0]);
  // R6
  f1_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_f[1] && !wr_f[1]) |=> !fresh[1]);
endmodule

bind cc_line_enc cc_line_enc_chk #(.LVL_W(LVL_W), .LVL_BLANK(LVL_BLANK), .LVL_HIGH(LVL_HIGH)) i_chk (
  .clk(clk), .rst_n(rst_n), .sol(sol), .tick(tick), .hcnt(hcnt),
  .data_act(data_act), .level(cc_level), .take_f(take_f), .wr_f(wr_f),
  .fresh(fresh)
);

// File: tb/test_cc_line_enc.sv
module test_cc_line_enc;
  localparam logic [9:0] BLANK = 10'd0;
  localparam logic [9:0] HIGH  = 10'd200;

  typedef struct {
    int         k;
    logic [9:0] lvl;
    logic       act;
    string      req;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [9:0] line_num = 0;
  logic field_id = 0, mode_50hz = 0, en_f0 = 1, en_f1 = 1;
  logic [2:0] line_ofs = 0;
  logic [15:0] f0_data = 0, f1_data = 0;
  logic f0_wr = 0, f1_wr = 0;
  logic [9:0] cc_level;
  logic data_act;

  int checks = 0, errors = 0;
  exp_t sb[$];
  logic pend [2];
  logic [15:0] held [2];

  always #10 clk = ~clk;

  cc_line_enc i_cc_line_enc (
    .clk(clk), .rst_n(rst_n), .line_num(line_num), .field_id(field_id),
    .line_ofs(line_ofs), .mode_50hz(mode_50hz), .en_f0(en_f0), .en_f1(en_f1),
    .f0_data(f0_data), .f0_wr(f0_wr), .f1_data(f1_data), .f1_wr(f1_wr),
    .cc_level(cc_level), .data_act(data_act)
  );

  function automatic logic par_bit(input logic [6:0] d);
    int ones = 0;
    for (int i = 0; i < 7; i++) if (d[i]) ones++;
    return (ones % 2 == 0);
  endfunction

  // driver: expected half-slot levels for one line
  task automatic push_line(input logic hit, input logic [15:0] raw, input string req);
    logic [15:0] pay;
    pay = {par_bit(raw[14:8]), raw[14:8], par_bit(raw[6:0]), raw[6:0]};
    for (int k = 0; k < 64; k++) begin
      exp_t e;
      int b;
      logic hi;
      e.k = k; e.req = req;
      b = (k - 8) / 2;
      if (!hit || k < 8 || k >= 60) begin
        e.act = 0; hi = 0;
      end else begin
        e.act = 1;
        if (b < 7) hi = (k % 2 == 0);
        else if (b < 9) hi = 0;
        else if (b == 9) hi = 1;
        else hi = pay[b - 10];
      end
      e.lvl = hi ? HIGH : BLANK;
      sb.push_back(e);
    end
  endtask

  // monitor: compare one sample against the scoreboard head
  task automatic mon_check();
    exp_t e;
    e = sb.pop_front();
    checks++;
    if (cc_level !== e.lvl || data_act !== e.act) begin
      errors++;
      $display("FAIL %s slot %0d: level=%0d act=%0b expected level=%0d act=%0b",
               e.req, e.k, cc_level, data_act, e.lvl, e.act);
    end
  endtask

  task automatic write_f(input logic f, input logic [15:0] d);
    if (f) begin f1_data = d; f1_wr = 1; end
    else   begin f0_data = d; f0_wr = 1; end
    @(negedge clk);
    f0_wr = 0; f1_wr = 0;
    pend[f] = 1; held[f] = d;
  endtask

  task automatic run_line(input int ln, input logic f, input string req);
    int len, k;
    logic hit, en;
    logic [15:0] raw;
    len = mode_50hz ? 864 : 858;
    en = f ? en_f1 : en_f0;
    hit = (ln == 21 + int'(line_ofs)) && en;
    raw = 16'h0000;
    if (hit) begin
      if (pend[f]) raw = held[f];
      pend[f] = 0;
    end
    push_line(hit, raw, req);
    line_num = 10'(ln); field_id = f;
    k = 0;
    for (int n = 0; n < len; n++) begin
      @(negedge clk);
      if (k < 64 && n == ((2 * k + 1) * len) / 128) begin
        mon_check();
        k++;
      end
    end
  endtask

  initial begin
    pend[0] = 0; pend[1] = 0; held[0] = 0; held[1] = 0;
    repeat (4) @(negedge clk);
    // R8: reset state
    checks++;
    if (cc_level !== BLANK || data_act !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset: level=%0d act=%0b expected level=0 act=0", cc_level, data_act);
    end
    rst_n = 1;
    @(negedge clk);
    run_line(20, 0, "R1");
    run_line(21, 0, "R8/R6 null after reset");
    write_f(0, 16'h9A35);
    run_line(20, 0, "R1");
    run_line(21, 0, "R2/R3 field0 data");
    run_line(22, 0, "R1");
    run_line(21, 0, "R6 null repeat");
    write_f(1, 16'h4C07);
    run_line(20, 1, "R1");
    run_line(21, 1, "R9 field1 data");
    write_f(0, 16'h1281);
    en_f0 = 0;
    run_line(20, 0, "R1");
    run_line(21, 0, "R7 disabled");
    en_f0 = 1;
    run_line(20, 0, "R1");
    run_line(21, 0, "R7 pending kept");
    line_ofs = 3;
    write_f(1, 16'h7F01);
    run_line(20, 1, "R1");
    run_line(21, 1, "R1 offset skips 21");
    run_line(24, 1, "R1 offset line");
    line_ofs = 0;
    mode_50hz = 1;
    write_f(0, 16'hD5AA);
    run_line(20, 0, "R4 50hz");
    run_line(21, 0, "R4/R5 50hz data");
    run_line(22, 0, "R4 50hz");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule